// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block runs the fetch side of a frame transmitter. Software places transmit descriptors in a small on-block descriptor memory through a write port. It marks each descriptor as owned by hardware and then strobes a doorbell. The engine walks the ring one descriptor at a time. For every owned descriptor it presents a frame-request record to a downstream consumer. The record carries the buffer address, byte length, end-of-frame flag, pad-request flag and CRC-request flag. The engine then waits for the consumer to report completion with a 10-bit status. It writes that status back into the descriptor, hands ownership back to software and pulses completion strobes.

The ring has no length register. A wrap flag in a descriptor, or the last slot of the memory, sends the walk back to the base slot. The engine stops when it meets a descriptor that software does not own. That also clears the doorbell flag. A doorbell write always re-arms the engine, even when it lands in the same cycle as that clear. Any doorbell write re-arms it, with no rising edge required, so descriptors added late are never stranded. A read port lets software inspect descriptors, including written-back status.

Top module: `txring_engine`

## Requirements
- R1: After reset the doorbell flag is clear, no request or strobe is driven, every descriptor word reads zero, and the walk pointer sits at slot BASE_SLOT.
- R2: Slot k occupies memory word 2k and word 2k+1. Word 2k holds control/status in bits 31:16 and the byte length in bits 15:0. Word 2k+1 holds the 32-bit buffer address. Slots below BASE_SLOT are never read or written by the engine.
- R3: Control bit 15 set means the descriptor is owned by hardware. The engine then issues a request with the word-1 address, the length, last = bit 11, pad = bit 14 and crc = bit 10. On a descriptor with bit 15 clear the engine stops and clears the doorbell flag.
- R4: A request stays valid with unchanged fields until req_ready is seen high.
- R5: On cpl_valid the engine rewrites word 2k. Bit 15 becomes 0, bits 14:10 are kept, bits 9:0 take cpl_status and bits 15:0 of the length are kept. The address word is left unchanged.
- R6: buf_done pulses for one cycle per retired descriptor. frame_done pulses in that cycle only when bit 11 was set. irq pulses in that cycle only when bit 12 was set.
- R7: After a descriptor with bit 13 set, or after slot DESC_SLOTS-1, the next slot is BASE_SLOT. Otherwise it is the following slot.
- R8: db_set sets the doorbell flag. A write while the flag is already set keeps it set. A set in the cycle the engine clears the flag wins. The engine then refetches, so a descriptor made owned in that same cycle is still sent.
- R9: With every ring slot owned, all are sent in ring order starting at the pointer. The walk then stops at the same position, now not owned.
- R10: Owned descriptors loaded without a doorbell write produce no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_wr_en | input | 1 | Software descriptor-memory write strobe |
| sw_wr_addr | input | MEM_AW | Word address for software write |
| sw_wr_data | input | 32 | Word to write |
| sw_rd_addr | input | MEM_AW | Word address for software read |
| sw_rd_data | output | 32 | Word read (combinational) |
| db_set | input | 1 | Doorbell write strobe |
| db_active | output | 1 | Doorbell flag |
| req_valid | output | 1 | Frame request valid |
| req_ready | input | 1 | Consumer accepts the request |
| req_addr | output | 32 | Buffer address |
| req_len | output | 16 | Buffer length in bytes |
| req_last | output | 1 | Last buffer of the frame |
| req_pad | output | 1 | Pad short frame |
| req_crc | output | 1 | Append CRC |
| cpl_valid | input | 1 | Consumer reports completion |
| cpl_status | input | 10 | Completion status bits |
| buf_done | output | 1 | Descriptor retired pulse |
| frame_done | output | 1 | Frame retired pulse |
| irq | output | 1 | Interrupt request pulse |

## Verification
The bench builds the engine with DESC_SLOTS = 8 and BASE_SLOT = 2. Slots 0 and 1 lie outside the ring and must stay untouched. With a non-zero base, both kinds of return to base can be seen: the wrap flag on slot 6, and the hard end of memory at slot 7. The six-slot ring is small enough to fill completely, so the full-equals-empty position case is reached. The write-back status pattern varies per descriptor, so a status or field mix-up shows up as a miscompare on readback.

// File: rtl/txr_pkg.sv
package txr_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;
    localparam int STAT_W = 10;

    // control/status half-word, most significant bit first
    typedef struct packed {
        logic              owned;   // bit 15
        logic              pad;     // bit 14
        logic              wrap;    // bit 13
        logic              intr;    // bit 12
        logic              last;    // bit 11
        logic              crc;     // bit 10
        logic [STAT_W-1:0] stat;    // bits 9:0
    } ctrl_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FETCH,
        S_REQ,
        S_WAIT,
        S_RETIRE
    } seq_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] addr;
        logic [LEN_W-1:0]  len;
        logic              last;
        logic              pad;
        logic              crc;
    } frame_req_t;

    function automatic ctrl_t ctrl_of(input logic [WORD_W-1:0] w);
        return ctrl_t'(w[WORD_W-1:LEN_W]);
    endfunction

    // descriptor word 0 as handed back to software
    function automatic logic [WORD_W-1:0] retire_word(input logic [WORD_W-1:0] w,
                                                      input logic [STAT_W-1:0] st);
        ctrl_t c;
        c       = ctrl_of(w);
        c.owned = 1'b0;
        c.stat  = st;
        return {c, w[LEN_W-1:0]};
    endfunction

endpackage

// File: rtl/txr_desc_mem.sv
module txr_desc_mem #(
    parameter int WORDS = 16,
    parameter int AW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_we,
    input  logic [AW-1:0] sw_waddr,
    input  logic [31:0]   sw_wdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_waddr,
    input  logic [31:0]   eng_wdata,
    input  logic [AW-1:0] rd_a_addr,
    output logic [31:0]   rd_a_data,
    input  logic [AW-1:0] rd_b_addr,
    output logic [31:0]   rd_b_data,
    input  logic [AW-1:0] rd_c_addr,
    output logic [31:0]   rd_c_data
);
    logic [31:0] mem_q [WORDS];

    always_ff @(posedge clk) begin
        for (int i = 0; i < WORDS; i++) begin
            if (rst)
                mem_q[i] <= '0;
            else if (eng_we && eng_waddr == AW'(i))
                mem_q[i] <= eng_wdata;      // retirement has priority
            else if (sw_we && sw_waddr == AW'(i))
                mem_q[i] <= sw_wdata;
        end
    end

    assign rd_a_data = mem_q[rd_a_addr];
    assign rd_b_data = mem_q[rd_b_addr];
    assign rd_c_data = mem_q[rd_c_addr];
endmodule

// File: rtl/txr_doorbell.sv
module txr_doorbell (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic active
);
    always_ff @(posedge clk) begin
        if (rst)
            active <= 1'b0;
        else if (set)
            active <= 1'b1;     // a software write beats the idle clear
        else if (clr)
            active <= 1'b0;
    end
endmodule

// File: rtl/txr_ring_ptr.sv
module txr_ring_ptr #(
    parameter int SLOTS     = 8,
    parameter int BASE_SLOT = 0,
    parameter int SW        = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  logic          wrap_flag,
    output logic [SW-1:0] slot
);
    localparam logic [SW-1:0] BASE = SW'(BASE_SLOT);
    localparam logic [SW-1:0] TOP  = SW'(SLOTS - 1);

    always_ff @(posedge clk) begin
        if (rst)
            slot <= BASE;
        else if (step) begin
            if (wrap_flag || slot == TOP)
                slot <= BASE;
            else
                slot <= slot + SW'(1);
        end
    end
endmodule

// File: rtl/txr_seq.sv
module txr_seq
    import txr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              db_active,
    input  logic [WORD_W-1:0] cur_w0,
    input  logic [WORD_W-1:0] cur_w1,
    input  logic              req_ready,
    input  logic              cpl_valid,
    input  logic [STAT_W-1:0] cpl_status,
    output logic              req_valid,
    output frame_req_t        req,
    output logic              wb_en,
    output logic [WORD_W-1:0] wb_data,
    output logic              step,
    output logic              step_wrap,
    output logic              db_clr,
    output logic              buf_done,
    output logic              frame_done,
    output logic              irq
);
    seq_state_e        state_q;
    logic [WORD_W-1:0] w0_q;
    logic [STAT_W-1:0] stat_q;
    frame_req_t        req_q;
    ctrl_t             cur_c;
    ctrl_t             held_c;

    assign cur_c  = ctrl_of(cur_w0);
    assign held_c = ctrl_of(w0_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            w0_q    <= '0;
            stat_q  <= '0;
            req_q   <= '0;
        end else begin
            unique case (state_q)
                S_IDLE:
                    if (db_active) state_q <= S_FETCH;
                S_FETCH:
                    if (cur_c.owned) begin
                        w0_q       <= cur_w0;
                        req_q.addr <= cur_w1;
                        req_q.len  <= cur_w0[LEN_W-1:0];
                        req_q.last <= cur_c.last;
                        req_q.pad  <= cur_c.pad;
                        req_q.crc  <= cur_c.crc;
                        state_q    <= S_REQ;
                    end else begin
                        state_q    <= S_IDLE;
                    end
                S_REQ:
                    if (req_ready) state_q <= S_WAIT;
                S_WAIT:
                    if (cpl_valid) begin
                        stat_q  <= cpl_status;
                        state_q <= S_RETIRE;
                    end
                S_RETIRE:
                    state_q <= S_FETCH;
                default:
                    state_q <= S_IDLE;
            endcase
        end
    end

    assign req_valid  = (state_q == S_REQ);
    assign req        = req_q;
    assign wb_en      = (state_q == S_RETIRE);
    assign wb_data    = retire_word(w0_q, stat_q);
    assign step       = wb_en;
    assign step_wrap  = held_c.wrap;
    assign db_clr     = (state_q == S_FETCH) && !cur_c.owned;
    assign buf_done   = wb_en;
    assign frame_done = wb_en && held_c.last;
    assign irq        = wb_en && held_c.intr;
endmodule

// File: rtl/txring_engine.sv
module txring_engine
    import txr_pkg::*;
#(
    parameter int DESC_SLOTS = 8,
    parameter int BASE_SLOT  = 0,
    parameter int SLOT_W     = $clog2(DESC_SLOTS),
    parameter int MEM_AW     = SLOT_W + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_wr_en,
    input  logic [MEM_AW-1:0] sw_wr_addr,
    input  logic [31:0]       sw_wr_data,
    input  logic [MEM_AW-1:0] sw_rd_addr,
    output logic [31:0]       sw_rd_data,
    input  logic              db_set,
    output logic              db_active,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [31:0]       req_addr,
    output logic [15:0]       req_len,
    output logic              req_last,
    output logic              req_pad,
    output logic              req_crc,
    input  logic              cpl_valid,
    input  logic [9:0]        cpl_status,
    output logic              buf_done,
    output logic              frame_done,
    output logic              irq
);
    localparam int MEM_WORDS = 2 * DESC_SLOTS;

    logic [SLOT_W-1:0] slot;
    logic [31:0]       cur_w0, cur_w1, wb_data;
    logic              wb_en, step, step_wrap, db_clr;
    frame_req_t        req;

    txr_desc_mem #(.WORDS(MEM_WORDS), .AW(MEM_AW)) u_mem (
        .clk       (clk),
        .rst       (rst),
        .sw_we     (sw_wr_en),
        .sw_waddr  (sw_wr_addr),
        .sw_wdata  (sw_wr_data),
        .eng_we    (wb_en),
        .eng_waddr ({slot, 1'b0}),
        .eng_wdata (wb_data),
        .rd_a_addr ({slot, 1'b0}),
        .rd_a_data (cur_w0),
        .rd_b_addr ({slot, 1'b1}),
        .rd_b_data (cur_w1),
        .rd_c_addr (sw_rd_addr),
        .rd_c_data (sw_rd_data)
    );

    txr_doorbell u_db (
        .clk    (clk),
        .rst    (rst),
        .set    (db_set),
        .clr    (db_clr),
        .active (db_active)
    );

    txr_ring_ptr #(.SLOTS(DESC_SLOTS), .BASE_SLOT(BASE_SLOT), .SW(SLOT_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .step      (step),
        .wrap_flag (step_wrap),
        .slot      (slot)
    );

    txr_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .db_active  (db_active),
        .cur_w0     (cur_w0),
        .cur_w1     (cur_w1),
        .req_ready  (req_ready),
        .cpl_valid  (cpl_valid),
        .cpl_status (cpl_status),
        .req_valid  (req_valid),
        .req        (req),
        .wb_en      (wb_en),
        .wb_data    (wb_data),
        .step       (step),
        .step_wrap  (step_wrap),
        .db_clr     (db_clr),
        .buf_done   (buf_done),
        .frame_done (frame_done),
        .irq        (irq)
    );

    assign req_addr = req.addr;
    assign req_len  = req.len;
    assign req_last = req.last;
    assign req_pad  = req.pad;
    assign req_crc  = req.crc;
endmodule

// File: rtl/txring_engine_chk.sv
module txring_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        db_set,
    input logic        db_active,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic [15:0] req_len,
    input logic        req_last,
    input logic        cpl_valid,
    input logic        buf_done,
    input logic        frame_done,
    input logic        irq
);
    a_r4_req_held: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_len) && $stable(req_last));

    a_r5_retire_after_cpl: assert property (@(posedge clk) disable iff (rst)
        buf_done |-> $past(cpl_valid));

    a_r6_frame_needs_buf: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> buf_done);

    a_r6_irq_needs_buf: assert property (@(posedge clk) disable iff (rst)
        irq |-> buf_done);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        buf_done |=> !buf_done);

    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        db_set |=> db_active);

    a_r10_req_needs_db: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> db_active);
endmodule

bind txring_engine txring_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .db_set     (db_set),
    .db_active  (db_active),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .req_last   (req_last),
    .cpl_valid  (cpl_valid),
    .buf_done   (buf_done),
    .frame_done (frame_done),
    .irq        (irq)
);

// File: tb/txring_engine_tb_top.sv
module txring_engine_tb_top;
    localparam int SLOTS = 8;
    localparam int BASE  = 2;
    localparam int AW    = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          sw_wr_en = 1'b0;
    logic [AW-1:0] sw_wr_addr = '0;
    logic [31:0]   sw_wr_data = '0;
    logic [AW-1:0] sw_rd_addr = '0;
    logic [31:0]   sw_rd_data;
    logic          db_set = 1'b0;
    logic          db_active;
    logic          req_valid;
    logic          req_ready = 1'b0;
    logic [31:0]   req_addr;
    logic [15:0]   req_len;
    logic          req_last, req_pad, req_crc;
    logic          cpl_valid = 1'b0;
    logic [9:0]    cpl_status = '0;
    logic          buf_done, frame_done, irq;

    txring_engine #(.DESC_SLOTS(SLOTS), .BASE_SLOT(BASE)) dut_i (.*);

    typedef struct {
        logic [31:0] addr;
        logic [15:0] len;
        logic        last, pad, crc;
    } exp_req_t;
    typedef struct {
        logic frame, intr;
    } exp_done_t;

    exp_req_t    q_req[$];
    exp_done_t   q_done[$];
    logic [31:0] mw0[SLOTS];
    logic [31:0] mw1[SLOTS];
    logic [31:0] exp_wb[SLOTS];
    int          mptr = BASE;
    int          push_seq = 0;
    int          cpl_seq = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    int          cyc = 0;
    int          hook_slot = 0;
    logic [31:0] hook_w0 = '0;
    logic [31:0] hook_w1 = '0;

    function automatic logic [9:0] st_of(input int k);
        return 10'((k * 97 + 13) & 1023);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural ring walk: everything owned from the model pointer on
    task automatic walk();
        while (mw0[mptr][31]) begin
            exp_req_t  r;
            exp_done_t d;
            r.addr = mw1[mptr];
            r.len  = mw0[mptr][15:0];
            r.last = mw0[mptr][27];
            r.pad  = mw0[mptr][30];
            r.crc  = mw0[mptr][26];
            d.frame = mw0[mptr][27];
            d.intr  = mw0[mptr][28];
            q_req.push_back(r);
            q_done.push_back(d);
            exp_wb[mptr] = {1'b0, mw0[mptr][30:26], st_of(push_seq), mw0[mptr][15:0]};
            push_seq++;
            mw0[mptr][31] = 1'b0;
            if (mw0[mptr][29] || mptr == SLOTS - 1) mptr = BASE;
            else mptr = mptr + 1;
        end
    endtask

    task automatic sw_write(input int a, input logic [31:0] d);
        @(negedge clk);
        sw_wr_en = 1'b1; sw_wr_addr = AW'(a); sw_wr_data = d;
        @(negedge clk);
        sw_wr_en = 1'b0;
    endtask

    task automatic load(input int s, input logic [31:0] w0, input logic [31:0] w1);
        sw_write(2 * s + 1, w1);
        sw_write(2 * s, w0);
        mw0[s] = w0;
        mw1[s] = w1;
    endtask

    task automatic ring();
        @(negedge clk); db_set = 1'b1;
        @(negedge clk); db_set = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        sw_rd_addr = AW'(a);
        #1 d = sw_rd_data;
    endtask

    // mode 0 plain, 1 add a descriptor while waiting, 2 doorbell on the idle-clear cycle
    task automatic serve(input int rw, input int cw, input int mode);
        int t = 0;
        while (!req_valid && t < 200) begin
            @(negedge clk); t++;
        end
        if (!req_valid) begin
            chk(1'b0, "R3 request never issued", 0, 1);
            return;
        end
        for (int i = 0; i < rw; i++) begin
            @(negedge clk);
            chk(req_valid, "R4 request dropped before accept", req_valid, 1);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        if (mode == 1) begin
            chk(db_active, "R8 flag set before repeat write", db_active, 1);
            sw_write(2 * hook_slot + 1, hook_w1);
            sw_wr_en = 1'b1; sw_wr_addr = AW'(2 * hook_slot); sw_wr_data = hook_w0;
            db_set = 1'b1;
            @(negedge clk);
            sw_wr_en = 1'b0; db_set = 1'b0;
            mw0[hook_slot] = hook_w0; mw1[hook_slot] = hook_w1;
            walk();
        end
        for (int i = 0; i < cw; i++) @(negedge clk);
        cpl_valid = 1'b1; cpl_status = st_of(cpl_seq); cpl_seq++;
        @(negedge clk);
        cpl_valid = 1'b0;
        if (mode == 2) begin
            @(negedge clk);
            sw_wr_en = 1'b1; sw_wr_addr = AW'(2 * hook_slot); sw_wr_data = hook_w0;
            db_set = 1'b1;
            @(negedge clk);
            sw_wr_en = 1'b0; db_set = 1'b0;
            chk(db_active, "R8 doorbell lost against idle clear", db_active, 1);
            mw0[hook_slot] = hook_w0;
            walk();
        end
    endtask

    task automatic settle_idle(input string tag);
        repeat (8) @(negedge clk);
        chk(!db_active, {tag, " doorbell flag not cleared at unowned slot"}, db_active, 0);
        chk(q_req.size() == 0, {tag, " requests missing"}, q_req.size(), 0);
        chk(q_done.size() == 0, {tag, " retirements missing"}, q_done.size(), 0);
    endtask

    task automatic check_slot(input int s, input string tag);
        logic [31:0] d;
        rd(2 * s, d);
        chk(d == exp_wb[s], {tag, " written-back word 0"}, d, exp_wb[s]);
        rd(2 * s + 1, d);
        chk(d == mw1[s], {tag, " address word changed"}, d, mw1[s]);
    endtask

    // reference comparison every clock, 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (req_valid && req_ready) begin
                if (q_req.size() == 0) chk(1'b0, "R10 unexpected request", req_addr, 0);
                else begin
                    exp_req_t e;
                    e = q_req.pop_front();
                    chk({req_addr, req_len, req_last, req_pad, req_crc} == {e.addr, e.len, e.last, e.pad, e.crc},
                        "R3 request fields", {req_addr, req_len, req_last, req_pad, req_crc},
                        {e.addr, e.len, e.last, e.pad, e.crc});
                end
            end else if (req_valid && q_req.size() == 0) begin
                chk(1'b0, "R10 request without pending work", req_addr, 0);
            end
            if (buf_done) begin
                if (q_done.size() == 0) chk(1'b0, "R6 unexpected retirement", 1, 0);
                else begin
                    exp_done_t d;
                    d = q_done.pop_front();
                    chk({frame_done, irq} == {d.frame, d.intr}, "R6 frame/irq pulses",
                        {frame_done, irq}, {d.frame, d.intr});
                end
            end else begin
                chk(!frame_done && !irq, "R6 pulse without retirement", {frame_done, irq}, 0);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < SLOTS; i++) begin
            mw0[i] = '0; mw1[i] = '0; exp_wb[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({req_valid, buf_done, frame_done, irq, db_active} == 5'b0, "R1 outputs after reset",
            {req_valid, buf_done, frame_done, irq, db_active}, 0);
        rd(2 * BASE, d);
        chk(d == 0, "R1 memory cleared", d, 0);

        // A: two-buffer frame then a one-buffer frame, starting at the base slot
        load(2, {16'hC000, 16'd60},   32'h1000_0000);
        load(3, {16'h9C00, 16'd1500}, 32'h1000_0800);
        load(4, {16'h8800, 16'd64},   32'h2000_0000);
        repeat (8) @(negedge clk);
        chk(!req_valid, "R10 owned descriptors without doorbell", req_valid, 0);
        ring(); walk();
        serve(0, 1, 0);
        serve(3, 0, 0);
        serve(1, 4, 0);
        settle_idle("R3");
        check_slot(2, "R5"); check_slot(3, "R5"); check_slot(4, "R5");

        // B: descriptor added mid-flight with a repeat doorbell; it carries the wrap flag
        load(5, {16'h8800, 16'd100}, 32'h3000_0000);
        hook_slot = 6; hook_w0 = {16'hB800, 16'd200}; hook_w1 = 32'h3000_1000;
        ring(); walk();
        serve(0, 6, 1);
        serve(0, 1, 0);
        settle_idle("R8");
        check_slot(5, "R5"); check_slot(6, "R7");

        // C: doorbell on the very cycle the engine clears it; wrap must have returned to slot 2
        load(2, {16'h8000, 16'd80}, 32'h4000_0000);
        sw_write(7, 32'h4000_1000); mw1[3] = 32'h4000_1000;
        hook_slot = 3; hook_w0 = {16'h8C00, 16'd90};
        ring(); walk();
        serve(0, 0, 2);
        serve(2, 2, 0);
        settle_idle("R8");
        check_slot(2, "R7"); check_slot(3, "R8");

        // D: whole ring owned; walk from slot 4 through the end of memory back to base
        load(4, {16'hC800, 16'd41},  32'h5000_0400);
        load(5, {16'h9800, 16'd52},  32'h5000_0500);
        load(6, {16'h8C00, 16'd63},  32'h5000_0600);
        load(7, {16'hD800, 16'd74},  32'h5000_0700);
        load(2, {16'h8000, 16'd85},  32'h5000_0200);
        load(3, {16'h9800, 16'd96},  32'h5000_0300);
        ring(); walk();
        chk(q_req.size() == 6, "R9 model saw full ring", q_req.size(), 6);
        for (int i = 0; i < 6; i++) serve(i % 3, (i * 2) % 5, 0);
        settle_idle("R9");
        for (int s = BASE; s < SLOTS; s++) check_slot(s, "R9");
        for (int a = 0; a < 2 * BASE; a++) begin
            rd(a, d);
            chk(d == 0, "R2 slot below base touched", d, 0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule